// File: doc/BRIEF.md
# Majority-Voted Oversampling UART Receiver

This block receives asynchronous serial characters of eight data bits and one stop bit. The raw line is sampled on every clock edge into a three-deep history, and the receiver works only on the 2-of-3 majority of that history. A single-cycle spike is therefore removed before bit recovery starts. Bit recovery runs on a 16x baud enable. A falling edge on the cleaned line opens a start bit, which must stay low for seven oversample ticks before it is trusted. Each later bit is sampled in the middle of its sixteen-tick window.

Finished characters go into an eight-entry first-word-fall-through FIFO together with their own framing-error bit. A break (all zeros, including the stop slot) lands in the FIFO as a zero byte with that bit set. A registered ready flag follows the FIFO fill level against a programmable trigger. An interrupt output copies the flag unless it is masked. A push into a full FIFO is lost and sets a sticky overrun flag, which stays set until a dedicated clear input resets it.

Top module: `uart_vote_rx`

## Requirements
- R1: The receiver sees the majority of the last three clock samples of `rxLine`. A line inversion lasting one clock cycle in the middle of a bit does not change the received byte or its error bit.
- R2: While idle, the receiver starts a character only on a tick where the voted line is 0 and was 1 at the previous tick. A line held at 1 for any length of time stores nothing.
- R3: A start bit is accepted only if the voted line is 0 on seven consecutive ticks, counting the tick that saw the falling edge. If a 1 is seen earlier, the receiver returns to idle without storing a character.
- R4: After the start window of 16 ticks, each of the 8 data bits is sampled on the 8th tick (count 7) of its 16-tick window. Bits arrive LSB first, and the byte appears on `rdData[7:0]`.
- R5: The stop bit is sampled at count 7 of its window, and the byte is pushed at that tick. `rdFrameErr` for that entry is 1 when the stop sample is 0, so a break gives data 0x00 with `rdFrameErr` = 1.
- R6: The FIFO holds 8 entries and presents its oldest entry on `rdData` and `rdFrameErr` while `fillLevel` is nonzero. A cycle with `rdStrobe` high and the FIFO not empty removes that entry. `fillLevel` gives the entry count, 0 to 8.
- R7: A push while `fillLevel` is 8 is dropped, even if a read happens in the same cycle, and it sets `overrun`. `overrun` stays at 1 until `ovrClear` is high in a cycle with no dropped push.
- R8: `readyFlag` is registered. After each clock edge it equals (new fill level >= `trigLevel`). It therefore sets when the fill reaches the trigger and clears only once the fill is below it.
- R9: `irq` is 1 exactly when `readyFlag` is 1 and `intMask` is 0.
- R10: Synchronous active-high `rst` empties the FIFO and clears `readyFlag` and `overrun`. It also sets the vote history to all ones and returns the receiver to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rxLine | input | 1 | Raw serial input, idle high |
| tickEn | input | 1 | One-cycle pulse at 16x the bit rate |
| rdStrobe | input | 1 | Removes the oldest FIFO entry |
| intMask | input | 1 | 1 blocks `irq` |
| trigLevel | input | 4 | Fill level at which `readyFlag` sets |
| ovrClear | input | 1 | Clears the sticky overrun flag |
| rdData | output | 8 | Oldest received byte |
| rdFrameErr | output | 1 | Framing error bit of the oldest byte |
| fillLevel | output | 4 | Entries in the FIFO |
| readyFlag | output | 1 | Fill level has reached the trigger |
| irq | output | 1 | Unmasked ready interrupt |
| overrun | output | 1 | Sticky flag for a dropped character |

## Verification
A wrong oversample count or bit index does not show until the stop tick of the same character. At that point the stored byte is shifted or merged with a neighbour, or the entry lands in the FIFO one tick early or late. A lost vote or edge-detect state either lets a glitch or a short low pulse open a phantom character, or swallows a real one. This shows as a `fillLevel` mismatch one character time later. Faults in the FIFO count or the flags show up on the very next clock, because the reference model is compared on every cycle.

// File: rtl/uvr_pkg.sv
package uvr_pkg;
  typedef struct packed {
    logic shiftEn;   // capture shiftBit into the assembly register
    logic shiftBit;  // voted line value at mid-bit
    logic push;      // character complete, write to FIFO
    logic pushErr;   // stop sample was low
  } rxStrobe_t;
endpackage

// File: rtl/uvr_ctrl.sv
module uvr_ctrl
  import uvr_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8,
  parameter int START_LOW = 7
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rxLine,
  input  logic       tickEn,
  output rxStrobe_t  strobe
);
  localparam int CW   = $clog2(OVS);
  localparam int BW   = $clog2(DATA_BITS);
  localparam int MID  = OVS / 2 - 1;
  localparam int LAST = OVS - 1;

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} rxState_e;

  logic [2:0]    hist;
  logic          voted;
  logic          lastVal;
  rxState_e      state;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitIdx;

  assign voted = (hist[0] & hist[1]) | (hist[1] & hist[2]) | (hist[0] & hist[2]);

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= 3'b111;
      lastVal <= 1'b1;
      state   <= S_IDLE;
      cnt     <= '0;
      bitIdx  <= '0;
    end else begin
      hist <= {hist[1:0], rxLine};
      if (tickEn) begin
        lastVal <= voted;
        unique case (state)
          S_IDLE: if (lastVal && !voted) begin
            state <= S_START;
            cnt   <= CW'(1);
          end
          S_START: begin
            if (cnt < CW'(START_LOW) && voted) begin
              state <= S_IDLE;
              cnt   <= '0;
            end else if (cnt == CW'(LAST)) begin
              state  <= S_DATA;
              cnt    <= '0;
              bitIdx <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_DATA: begin
            if (cnt == CW'(LAST)) begin
              cnt <= '0;
              if (bitIdx == BW'(DATA_BITS - 1)) state <= S_STOP;
              else bitIdx <= bitIdx + 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          S_STOP: begin
            if (cnt == CW'(MID)) begin
              state <= S_IDLE;
              cnt   <= '0;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end
          default: state <= S_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    strobe.shiftEn  = tickEn && (state == S_DATA) && (cnt == CW'(MID));
    strobe.shiftBit = voted;
    strobe.push     = tickEn && (state == S_STOP) && (cnt == CW'(MID));
    strobe.pushErr  = ~voted;
  end
endmodule

// File: rtl/uvr_data.sv
module uvr_data
  import uvr_pkg::*;
#(
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  rxStrobe_t                    strobe,
  input  logic                         rdStrobe,
  input  logic                         ovrClear,
  input  logic [$clog2(DEPTH+1)-1:0]   trigLevel,
  output logic [DATA_BITS-1:0]         rdData,
  output logic                         rdFrameErr,
  output logic [$clog2(DEPTH+1)-1:0]   fillLevel,
  output logic                         readyFlag,
  output logic                         overrun
);
  localparam int PW = $clog2(DEPTH);
  localparam int FW = $clog2(DEPTH + 1);

  logic [DATA_BITS-1:0] shreg;
  logic [DATA_BITS:0]   mem [DEPTH];
  logic [PW-1:0]        wrPtr, rdPtr;
  logic [FW-1:0]        fill, fillNext;
  logic                 full, pop, accept, drop;

  assign full     = (fill == FW'(DEPTH));
  assign pop      = rdStrobe && (fill != '0);
  assign accept   = strobe.push && !full;
  assign drop     = strobe.push && full;
  assign fillNext = fill + FW'(accept) - FW'(pop);

  always_ff @(posedge clk) begin
    if (strobe.shiftEn) shreg <= {strobe.shiftBit, shreg[DATA_BITS-1:1]};
    if (accept) mem[wrPtr] <= {strobe.pushErr, shreg};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fill      <= '0;
      readyFlag <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (accept) wrPtr <= wrPtr + 1'b1;
      if (pop)    rdPtr <= rdPtr + 1'b1;
      fill      <= fillNext;
      readyFlag <= (fillNext >= trigLevel);
      if (drop)          overrun <= 1'b1;
      else if (ovrClear) overrun <= 1'b0;
    end
  end

  assign rdData     = mem[rdPtr][DATA_BITS-1:0];
  assign rdFrameErr = mem[rdPtr][DATA_BITS];
  assign fillLevel  = fill;
endmodule

// File: rtl/uart_vote_rx.sv
module uart_vote_rx
  import uvr_pkg::*;
#(
  parameter int OVS       = 16,
  parameter int DATA_BITS = 8,
  parameter int DEPTH     = 8,
  parameter int START_LOW = 7
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       rxLine,
  input  logic                       tickEn,
  input  logic                       rdStrobe,
  input  logic                       intMask,
  input  logic [$clog2(DEPTH+1)-1:0] trigLevel,
  input  logic                       ovrClear,
  output logic [DATA_BITS-1:0]       rdData,
  output logic                       rdFrameErr,
  output logic [$clog2(DEPTH+1)-1:0] fillLevel,
  output logic                       readyFlag,
  output logic                       irq,
  output logic                       overrun
);
  rxStrobe_t strobe;

  uvr_ctrl #(.OVS(OVS), .DATA_BITS(DATA_BITS), .START_LOW(START_LOW)) u_ctrl (
    .clk(clk), .rst(rst), .rxLine(rxLine), .tickEn(tickEn), .strobe(strobe)
  );

  uvr_data #(.DATA_BITS(DATA_BITS), .DEPTH(DEPTH)) u_data (
    .clk(clk), .rst(rst), .strobe(strobe), .rdStrobe(rdStrobe),
    .ovrClear(ovrClear), .trigLevel(trigLevel), .rdData(rdData),
    .rdFrameErr(rdFrameErr), .fillLevel(fillLevel), .readyFlag(readyFlag),
    .overrun(overrun)
  );

  assign irq = readyFlag & ~intMask;
endmodule

// File: rtl/uvr_check.sv
module uvr_check #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rdStrobe,
  input logic                       intMask,
  input logic                       ovrClear,
  input logic [$clog2(DEPTH+1)-1:0] trigLevel,
  input logic [$clog2(DEPTH+1)-1:0] fillLevel,
  input logic                       readyFlag,
  input logic                       irq,
  input logic                       overrun
);
  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst)
    int'(fillLevel) <= DEPTH);  // R6

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (int'(fillLevel) <= int'($past(fillLevel)) + 1) &&
             (int'($past(fillLevel)) <= int'(fillLevel) + 1));  // R6

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    intMask |-> !irq);  // R9

  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    overrun && !ovrClear |=> overrun);  // R7

  AST_READY_HOLD: assert property (@(posedge clk) disable iff (rst)
    readyFlag && !rdStrobe && (trigLevel == $past(trigLevel)) |=> readyFlag);  // R8
endmodule

bind uart_vote_rx uvr_check #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .rdStrobe(rdStrobe), .intMask(intMask),
  .ovrClear(ovrClear), .trigLevel(trigLevel), .fillLevel(fillLevel),
  .readyFlag(readyFlag), .irq(irq), .overrun(overrun)
);

// File: tb/sim_uart_vote_rx.sv
`timescale 1ns/1ps
module sim_uart_vote_rx;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rxLine = 1'b1;
  logic       tickEn = 1'b0;
  logic       rdStrobe = 1'b0;
  logic       intMask = 1'b0;
  logic [3:0] trigLevel = 4'd1;
  logic       ovrClear = 1'b0;
  logic [7:0] rdData;
  logic       rdFrameErr;
  logic [3:0] fillLevel;
  logic       readyFlag, irq, overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  uart_vote_rx u0 (
    .clk(clk), .rst(rst), .rxLine(rxLine), .tickEn(tickEn), .rdStrobe(rdStrobe),
    .intMask(intMask), .trigLevel(trigLevel), .ovrClear(ovrClear), .rdData(rdData),
    .rdFrameErr(rdFrameErr), .fillLevel(fillLevel), .readyFlag(readyFlag),
    .irq(irq), .overrun(overrun)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // 16x tick: one cycle in four
  int divCnt = 0;
  always @(negedge clk) begin
    #2;
    tickEn <= (divCnt == 3);
    divCnt <= (divCnt + 1) % 4;
  end

  // ---------------- behavioural reference model ----------------
  int hs[3];
  int mLast, mState, mCnt, mBit, mShr;
  int q[$];
  int mOvr, mRdy;

  always @(posedge clk) begin
    if (rst) begin
      hs = '{1, 1, 1};
      mLast = 1; mState = 0; mCnt = 0; mBit = 0;
      q.delete(); mOvr = 0; mRdy = 0;
    end else begin
      int v, pushNow, pushErr, accept, drop, popNow;
      v = (hs[0] + hs[1] + hs[2]) >= 2 ? 1 : 0;
      pushNow = 0; pushErr = 0;
      if (tickEn) begin
        case (mState)
          0: if (mLast == 1 && v == 0) begin mState = 1; mCnt = 1; end
          1: if (mCnt < 7 && v == 1) begin mState = 0; mCnt = 0; end
             else if (mCnt == 15) begin mState = 2; mCnt = 0; mBit = 0; end
             else mCnt++;
          2: begin
               if (mCnt == 7) mShr = (mShr >> 1) | (v << 7);
               if (mCnt == 15) begin
                 mCnt = 0;
                 if (mBit == 7) mState = 3; else mBit++;
               end else mCnt++;
             end
          default: if (mCnt == 7) begin
               pushNow = 1; pushErr = (v == 0);
               mState = 0; mCnt = 0;
             end else mCnt++;
        endcase
        mLast = v;
      end
      hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = rxLine;
      accept = pushNow && q.size() < 8;
      drop   = pushNow && q.size() == 8;
      popNow = rdStrobe && q.size() > 0;
      if (popNow) void'(q.pop_front());
      if (accept) q.push_back((pushErr << 8) | (mShr & 8'hFF));
      if (drop) mOvr = 1; else if (ovrClear) mOvr = 0;
      mRdy = (q.size() >= int'(trigLevel)) ? 1 : 0;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R6 fillLevel", fillLevel, q.size());
      chk("R8 readyFlag", readyFlag, mRdy);
      chk("R9 irq", irq, mRdy & ~intMask);
      chk("R7 overrun", overrun, mOvr);
      if (q.size() > 0) begin
        chk("R4 rdData", rdData, q[0] & 8'hFF);
        chk("R5 rdFrameErr", rdFrameErr, (q[0] >> 8) & 1);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic holdBit(input logic b, input bit glitch);
    rxLine = b;
    if (glitch) begin
      repeat (31) @(negedge clk);
      #2 rxLine = ~b;
      @(negedge clk);
      #2 rxLine = b;
      repeat (32) @(negedge clk);
    end else begin
      repeat (64) @(negedge clk);
    end
    #2;
  endtask

  task automatic sendByte(input logic [7:0] d, input logic stopBit, input bit glitch);
    @(negedge clk); #2;
    holdBit(1'b0, glitch);
    for (int i = 0; i < 8; i++) holdBit(d[i], glitch);
    holdBit(stopBit, glitch);
    holdBit(1'b1, 1'b0);
    holdBit(1'b1, 1'b0);
  endtask

  task automatic popOne();
    @(negedge clk); #2 rdStrobe = 1'b1;
    @(negedge clk); #2 rdStrobe = 1'b0;
  endtask

  task automatic drain();
    while (fillLevel != 0) popOne();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    chk("R10 fillLevel", fillLevel, 0);
    chk("R10 readyFlag", readyFlag, 0);
    chk("R10 overrun", overrun, 0);
    #2 rst = 1'b0;
    @(negedge clk);

    // R4: clean byte, LSB first
    sendByte(8'hA5, 1'b1, 1'b0);
    @(negedge clk);
    chk("R4 byte A5", rdData, 8'hA5);
    chk("R5 clean stop", rdFrameErr, 0);
    chk("R9 irq unmasked", irq, 1);
    popOne();

    // R1: one-cycle glitches inside every bit are filtered
    sendByte(8'h3C, 1'b1, 1'b1);
    @(negedge clk);
    chk("R1 glitched byte", rdData, 8'h3C);
    chk("R1 glitched stop", rdFrameErr, 0);
    popOne();

    // R2: long idle stores nothing
    repeat (2000) @(negedge clk);
    chk("R2 idle fill", fillLevel, 0);

    // R3: low pulse of ~5 ticks is rejected
    #2 rxLine = 1'b0;
    repeat (20) @(negedge clk);
    #2 rxLine = 1'b1;
    repeat (1500) @(negedge clk);
    chk("R3 short start fill", fillLevel, 0);

    // R5: framing error and break
    sendByte(8'h5A, 1'b0, 1'b0);
    sendByte(8'h00, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 ferr byte", rdData, 8'h5A);
    chk("R5 ferr flag", rdFrameErr, 1);
    popOne();
    chk("R5 break byte", rdData, 8'h00);
    chk("R5 break flag", rdFrameErr, 1);
    popOne();

    // R8/R9: trigger at 3, mask
    #2 trigLevel = 4'd3;
    sendByte(8'h11, 1'b1, 1'b0);
    sendByte(8'h22, 1'b1, 1'b0);
    chk("R8 below trigger", readyFlag, 0);
    sendByte(8'h33, 1'b1, 1'b0);
    chk("R8 at trigger", readyFlag, 1);
    #2 intMask = 1'b1;
    @(negedge clk);
    chk("R9 masked irq", irq, 0);
    popOne();
    @(negedge clk);
    chk("R8 below again", readyFlag, 0);
    #2 intMask = 1'b0;
    drain();

    // R7: overrun
    #2 trigLevel = 4'd8;
    for (int i = 0; i < 9; i++) sendByte(8'(8'h40 + i), 1'b1, 1'b0);
    chk("R7 full", fillLevel, 8);
    chk("R7 overrun set", overrun, 1);
    chk("R6 oldest kept", rdData, 8'h40);
    @(negedge clk); #2 ovrClear = 1'b1;
    @(negedge clk); #2 ovrClear = 1'b0;
    @(negedge clk);
    chk("R7 overrun cleared", overrun, 0);
    drain();
    repeat (10) @(negedge clk);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule